// File: doc/BRIEF.md
# Predicated Commit Stage

This block is the last stage of a small in-order pipeline that executes conditional moves and predicated loads. Each cycle it may receive one finished result from the execute stage, together with the operation class, the destination register, the result value, the operand that serves as the predicate and any fault that execution raised. Only at this point, just before the register write, does it decide whether the instruction takes effect. An instruction whose predicate is true either writes the register file or, if it carries a fault, raises a precise exception. An instruction whose predicate is false is annulled. It still used its slot and its cycle, but it leaves no trace: no register write, and no exception even if it faulted.

Unpredicated ALU results always take effect. A move-if-zero class and its complement, move-if-nonzero, allow branch-free sequences such as absolute value, built from one plain move followed by one conditional move. The predicated load takes effect only when its predicate operand is nonzero, so a load through an invalid pointer can be placed on the rarely taken path without risk. Two counters record how many instructions committed and how many were annulled.

Top module: `pred_commit_stage`

## Requirements
- R1: An ALU-class input (op code 2'b00) always commits. It writes its result and increments the commit counter by one.
- R2: A move-if-zero input (op code 2'b01) commits only when the predicate operand is zero. Otherwise it is annulled.
- R3: A move-if-nonzero input (op code 2'b10) commits only when the predicate operand is nonzero. Otherwise it is annulled.
- R4: A predicated load (op code 2'b11) commits only when the predicate operand is nonzero. Otherwise it is annulled.
- R5: An annulled input produces no register write and no exception, even when it carries a fault. It increments the annul counter by one and leaves the commit counter unchanged.
- R6: A committing input that carries a fault produces no register write and neither counter changes. Instead, exc_valid is high for exactly one cycle with exc_cause equal to the input's cause. exc_cause is zero whenever exc_valid is low.
- R7: The valid input in the cycle right after a faulting commit is flushed. It produces no write, no exception and no counter change.
- R8: A commit to register 0 produces no write, but it still increments the commit counter.
- R9: rf_we, rf_waddr and rf_wdata are registered. They show a commit in the cycle after the input is presented, and rf_we is high for that single cycle.
- R10: Synchronous active-high reset clears both counters, rf_we and exc_valid. It also ends any pending flush.
- R11: A cycle with in_valid low changes neither counter and produces neither a write nor an exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Execute stage presents a result this cycle |
| in_op | input | 2 | Operation class: 00 ALU, 01 move-if-zero, 10 move-if-nonzero, 11 predicated load |
| in_rd | input | 5 | Destination register index |
| in_result | input | 32 | Result or loaded value |
| in_pred | input | 32 | Predicate operand value |
| in_fault | input | 1 | Execution raised a fault |
| in_cause | input | 4 | Fault cause code |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| exc_valid | output | 1 | Precise exception pulse |
| exc_cause | output | 4 | Exception cause, zero when no pulse |
| commit_count | output | 16 | Committed-instruction counter, wraps |
| annul_count | output | 16 | Annulled-instruction counter, wraps |

## Verification
Several properties are checked on every cycle. A false predicate never reaches the write port or the exception output. A write never targets register 0, and a write and an exception never occur together. The exception lasts a single cycle, and each counter either holds or steps by one. Other behaviours can only be shown by the bench's reference model: the exact cycle at which each output appears, the written data, and the cause code carried through. The model also covers flushing of the input after a fault, including a second fault arriving in the flushed slot, and a reset that lands in the middle of a flush.

// File: rtl/pce_pkg.sv
package pce_pkg;

    typedef enum logic [1:0] {
        OP_ALU   = 2'b00,
        OP_MOVZ  = 2'b01,
        OP_MOVNZ = 2'b10,
        OP_PLOAD = 2'b11
    } op_class_e;

    typedef enum logic [2:0] {
        OUT_IDLE   = 3'd0,
        OUT_COMMIT = 3'd1,
        OUT_ANNUL  = 3'd2,
        OUT_FAULT  = 3'd3,
        OUT_DROP   = 3'd4
    } outcome_e;

endpackage

// File: rtl/pce_pred_eval.sv
module pce_pred_eval
    import pce_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  op_class_e       op,
    input  logic [XLEN-1:0] pred,
    output logic            pred_true
);
    logic pred_zero;

    always_comb begin
        pred_zero = (pred == '0);
        unique case (op)
            OP_ALU:   pred_true = 1'b1;
            OP_MOVZ:  pred_true = pred_zero;
            OP_MOVNZ: pred_true = !pred_zero;
            OP_PLOAD: pred_true = !pred_zero;
            default:  pred_true = 1'b0;
        endcase
    end

endmodule

// File: rtl/pce_outcome.sv
module pce_outcome
    import pce_pkg::*;
(
    input  logic     valid,
    input  logic     flush,
    input  logic     pred_true,
    input  logic     fault,
    output outcome_e outcome
);
    always_comb begin
        if (!valid)          outcome = OUT_IDLE;
        else if (flush)      outcome = OUT_DROP;
        else if (!pred_true) outcome = OUT_ANNUL;
        else if (fault)      outcome = OUT_FAULT;
        else                 outcome = OUT_COMMIT;
    end

endmodule

// File: rtl/pce_event_counter.sv
module pce_event_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (inc) count_d = count_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    assign count = count_q;

    // R5, R11: a counter moves only on its event, and then by exactly one
    a_r11_count_holds: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(count_q));
    a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
        inc |=> (count_q == $past(count_q) + W'(1)));

endmodule

// File: rtl/pred_commit_stage.sv
module pred_commit_stage
    import pce_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NREG    = 32,
    parameter int CAUSE_W = 4,
    parameter int CNT_W   = 16,
    localparam int AW     = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [1:0]         in_op,
    input  logic [AW-1:0]      in_rd,
    input  logic [XLEN-1:0]    in_result,
    input  logic [XLEN-1:0]    in_pred,
    input  logic               in_fault,
    input  logic [CAUSE_W-1:0] in_cause,
    output logic               rf_we,
    output logic [AW-1:0]      rf_waddr,
    output logic [XLEN-1:0]    rf_wdata,
    output logic               exc_valid,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic [CNT_W-1:0]   commit_count,
    output logic [CNT_W-1:0]   annul_count
);
    typedef struct packed {
        logic               we;
        logic [AW-1:0]      waddr;
        logic [XLEN-1:0]    wdata;
        logic               exc;
        logic [CAUSE_W-1:0] cause;
        logic               flush;
    } stage_t;

    stage_t    st_d, st_q;
    op_class_e op;
    logic      pred_true;
    outcome_e  outcome;
    logic      inc_commit, inc_annul;

    assign op = op_class_e'(in_op);

    pce_pred_eval #(.XLEN(XLEN)) i_pred (
        .op        (op),
        .pred      (in_pred),
        .pred_true (pred_true)
    );

    pce_outcome i_outcome (
        .valid     (in_valid),
        .flush     (st_q.flush),
        .pred_true (pred_true),
        .fault     (in_fault),
        .outcome   (outcome)
    );

    always_comb begin
        st_d       = st_q;
        st_d.we    = 1'b0;
        st_d.exc   = 1'b0;
        st_d.cause = '0;
        st_d.flush = 1'b0;
        inc_commit = 1'b0;
        inc_annul  = 1'b0;
        unique case (outcome)
            OUT_COMMIT: begin
                inc_commit = 1'b1;
                if (in_rd != '0) begin
                    st_d.we    = 1'b1;
                    st_d.waddr = in_rd;
                    st_d.wdata = in_result;
                end
            end
            OUT_ANNUL: inc_annul = 1'b1;
            OUT_FAULT: begin
                st_d.exc   = 1'b1;
                st_d.cause = in_cause;
                st_d.flush = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    pce_event_counter #(.W(CNT_W)) i_commit_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (inc_commit),
        .count (commit_count)
    );

    pce_event_counter #(.W(CNT_W)) i_annul_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (inc_annul),
        .count (annul_count)
    );

    assign rf_we     = st_q.we;
    assign rf_waddr  = st_q.waddr;
    assign rf_wdata  = st_q.wdata;
    assign exc_valid = st_q.exc;
    assign exc_cause = st_q.cause;

    // R5: a false predicate leaves no architectural trace
    a_r5_annul_silent: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !st_q.flush && !pred_true) |=> (!rf_we && !exc_valid));
    // R4: a predicated load with a zero predicate never faults or writes
    a_r4_load_zero_pred: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !st_q.flush && op == OP_PLOAD && in_pred == '0) |=> (!rf_we && !exc_valid));
    // R8: register 0 is never written
    a_r8_no_zero_write: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (rf_waddr != '0));
    // R6: a write and an exception never coincide
    a_r6_exc_blocks_write: assert property (@(posedge clk) disable iff (rst)
        !(rf_we && exc_valid));
    // R6, R7: the exception is a single-cycle pulse
    a_r7_exc_single: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> !exc_valid);
    // R6: cause is zero outside a pulse
    a_r6_cause_quiet: assert property (@(posedge clk) disable iff (rst)
        !exc_valid |-> (exc_cause == '0));
    // R1: a valid, unflushed, fault-free ALU op always counts as a commit
    a_r1_alu_commits: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !st_q.flush && op == OP_ALU && !in_fault)
            |=> (commit_count == $past(commit_count) + CNT_W'(1)));

endmodule

// File: tb/test_pred_commit_stage.sv
module test_pred_commit_stage;
    localparam int XLEN = 32;
    localparam int AW   = 5;
    localparam int CW   = 4;
    localparam int NW   = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [1:0]      in_op = 2'b00;
    logic [AW-1:0]   in_rd = '0;
    logic [XLEN-1:0] in_result = '0;
    logic [XLEN-1:0] in_pred = '0;
    logic            in_fault = 1'b0;
    logic [CW-1:0]   in_cause = '0;
    logic            rf_we;
    logic [AW-1:0]   rf_waddr;
    logic [XLEN-1:0] rf_wdata;
    logic            exc_valid;
    logic [CW-1:0]   exc_cause;
    logic [NW-1:0]   commit_count;
    logic [NW-1:0]   annul_count;

    pred_commit_stage i_pred_commit_stage (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_rd(in_rd),
        .in_result(in_result), .in_pred(in_pred), .in_fault(in_fault),
        .in_cause(in_cause), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .exc_valid(exc_valid), .exc_cause(exc_cause),
        .commit_count(commit_count), .annul_count(annul_count)
    );

    always #10 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    started = 0;
    string cur_tag = "R10";
    string exp_tag = "R10";

    // behavioural reference
    bit          m_we, m_exc, m_flush;
    int unsigned m_waddr, m_wdata, m_cause, m_commit, m_annul;

    function automatic bit taken(int unsigned op, int unsigned p);
        case (op)
            0: return 1;
            1: return p == 0;
            default: return p != 0;
        endcase
    endfunction

    always @(posedge clk) begin
        started <= 1;
        exp_tag = cur_tag;
        m_we = 0; m_exc = 0; m_cause = 0;
        if (rst) begin
            m_commit = 0; m_annul = 0; m_flush = 0;
        end else if (in_valid && !m_flush) begin
            if (!taken(in_op, in_pred)) m_annul = (m_annul + 1) % 65536;
            else if (in_fault) begin
                m_exc = 1; m_cause = in_cause; m_flush = 1;
            end else begin
                m_commit = (m_commit + 1) % 65536;
                if (in_rd != 0) begin m_we = 1; m_waddr = in_rd; m_wdata = in_result; end
            end
        end else m_flush = 0;
        if (!rst && in_valid && m_flush && !m_exc) m_flush = 0;
    end

    task automatic cmp(string what, int unsigned act, int unsigned exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", exp_tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (started) begin
            cmp("rf_we", rf_we, m_we);
            if (m_we) begin
                cmp("rf_waddr", rf_waddr, m_waddr);
                cmp("rf_wdata", rf_wdata, m_wdata);
            end
            cmp("exc_valid", exc_valid, m_exc);
            cmp("exc_cause", exc_cause, m_cause);
            cmp("commit_count", commit_count, m_commit);
            cmp("annul_count", annul_count, m_annul);
        end
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL all watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic issue(string tag, logic [1:0] op, logic [AW-1:0] rd,
                         logic [XLEN-1:0] res, logic [XLEN-1:0] pred,
                         logic flt, logic [CW-1:0] cause);
        @(negedge clk);
        cur_tag = tag; in_valid = 1; in_op = op; in_rd = rd; in_result = res;
        in_pred = pred; in_fault = flt; in_cause = cause;
    endtask

    task automatic idle(string tag);
        @(negedge clk);
        cur_tag = tag; in_valid = 0; in_fault = 1; in_cause = 4'hF;
        in_pred = '0; in_op = 2'b00; in_rd = 5'd7;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_tag = "R10";
        rst = 0;
        idle("R11");
        issue("R1", 2'b00, 5'd3, 32'h1111_0001, 32'h5, 0, 0);
        issue("R1", 2'b00, 5'd4, 32'h2222_0002, 32'h0, 0, 0);
        idle("R9");
        issue("R2", 2'b01, 5'd5, 32'hAAAA_0005, 32'h0, 0, 0);
        issue("R2", 2'b01, 5'd5, 32'hBBBB_0005, 32'h9, 0, 0);
        issue("R3", 2'b10, 5'd6, 32'hCCCC_0006, 32'h1, 0, 0);
        issue("R3", 2'b10, 5'd6, 32'hDDDD_0006, 32'h0, 0, 0);
        // absolute value: plain move then move-if-nonzero of negated value
        issue("R3", 2'b00, 5'd9, 32'hFFFF_FFFB, 32'h0, 0, 0);
        issue("R3", 2'b10, 5'd9, 32'h0000_0005, 32'h1, 0, 0);
        issue("R4", 2'b11, 5'd10, 32'h1234_5678, 32'h8000_0000, 0, 0);
        issue("R4", 2'b11, 5'd10, 32'h8765_4321, 32'h0, 0, 0);
        issue("R5", 2'b11, 5'd11, 32'h0, 32'h0, 1, 4'h5);
        issue("R5", 2'b01, 5'd11, 32'h0, 32'h3, 1, 4'h2);
        issue("R6", 2'b11, 5'd12, 32'h0, 32'h40, 1, 4'hD);
        issue("R7", 2'b00, 5'd13, 32'h7777, 32'h0, 0, 0);
        issue("R6", 2'b00, 5'd14, 32'h0, 32'h0, 1, 4'h3);
        issue("R7", 2'b11, 5'd15, 32'h0, 32'h1, 1, 4'h9);
        issue("R7", 2'b00, 5'd16, 32'h6666, 32'h0, 0, 0);
        issue("R6", 2'b10, 5'd17, 32'h0, 32'h2, 1, 4'hA);
        idle("R7");
        issue("R7", 2'b00, 5'd18, 32'h5555, 32'h0, 0, 0);
        issue("R8", 2'b00, 5'd0, 32'hDEAD, 32'h0, 0, 0);
        issue("R8", 2'b01, 5'd0, 32'hBEEF, 32'h0, 0, 0);
        issue("R6", 2'b00, 5'd1, 32'h0, 32'h0, 1, 4'h1);
        @(negedge clk); cur_tag = "R10"; rst = 1; in_valid = 1;
        @(negedge clk); rst = 0;
        issue("R10", 2'b00, 5'd2, 32'h4444, 32'h0, 0, 0);
        for (int i = 0; i < 3000; i++) begin
            issue("R2/R3/R5 random", 2'($urandom), 5'($urandom_range(0, 4)),
                  $urandom, ($urandom_range(0, 1) != 0) ? $urandom : 32'h0,
                  ($urandom_range(0, 5) == 0), 4'($urandom));
            if ($urandom_range(0, 7) == 0) in_valid = 0;
        end
        idle("R11");
        idle("R11");
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule